// File: doc/BRIEF.md
# Up-Counting PWM Timer Channel

This block is a single-channel timer that produces a pulse-width-modulated output. A prescaler divides the block clock down to a counter tick. An up-counter runs from zero to an auto-reload limit and then wraps back to zero. A compare value splits each period into an active part and an inactive part.

Software reaches seven registers through a simple write and read port:

- control
- mode
- output enable
- prescaler
- auto-reload
- counter
- compare

The auto-reload and compare registers are double-buffered. When their preload is enabled, new values take effect only at the wrap. The prescaler is always buffered. A block-level clock-enable input freezes the whole timer while it is low.

Top module: `pwm_timer_top`

## Requirements
- R1: After reset every register reads 0, except auto-reload, which reads all ones. `pwm_o` and `update_o` are low.
- R2: The register addresses are control=0, mode=1, output enable=2, prescaler=3, auto-reload=4, counter=5 and compare=6. Control has run in bit 0 and auto-reload preload in bit 7. Mode has the compare mode in bits 6:4 and compare preload in bit 3. Output enable is bit 0. Reading the prescaler, auto-reload or compare register returns the value last written by software.
- R3: While control bit 0 is set, the counter advances once every PSC+1 clocks. While it is clear, the counter holds.
- R4: The counter wraps from the auto-reload value to 0, so one period lasts (ARR+1)*(PSC+1) clocks. `update_o` is high for the first clock in which the counter reads 0 after a wrap.
- R5: Mode 6 drives `pwm_o` high while CNT < CMP. CMP=0 gives an output that is always low. CMP > ARR gives an output that is always high.
- R6: Mode 7 inverts the relation of mode 6. Mode 4 forces the output low and mode 5 forces it high. Every other mode value gives a low output.
- R7: With a preload bit set, a write to auto-reload or compare reaches the active value only at the wrap. With the bit clear, the write takes effect at once. A written prescaler value always waits for the wrap.
- R8: With output enable bit 0 clear, `pwm_o` is low.
- R9: While `clk_en_i` is low, the counter holds, register writes are ignored, `pwm_o` is low and no update pulse occurs.
- R10: Writing the counter register loads the counter and restarts the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Block clock enable; the timer has no effect while this is low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for `addr_i` (combinational) |
| pwm_o | output | 1 | PWM output, active high |
| update_o | output | 1 | One-clock pulse after each wrap |

## Verification
A register write lands at the clock edge inside the write strobe. Compare, mode and output-enable changes without preload show on `pwm_o` in the same cycle as that edge, because the output is combinational from registered state. Counter values follow R3: after a counter write, the counter reads the loaded value until PSC+1 edges have passed, and the bench samples it on the falling edges just before and just after that step. Period shape is checked window by window between `update_o` pulses, counting clocks and high samples on falling edges. Configuration for the next window is written during an unmeasured window, so preloaded values become due exactly at the next pulse.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_OEN  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PSC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ARR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd6;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_ARP_BIT = 7;
  localparam int unsigned MODE_LSB     = 4;
  localparam int unsigned MODE_CPE_BIT = 3;
  localparam int unsigned OEN_BIT      = 0;

  typedef enum logic [2:0] {
    OCM_FORCE_LO = 3'd4,
    OCM_FORCE_HI = 3'd5,
    OCM_PWM_LO   = 3'd6,
    OCM_PWM_HI   = 3'd7
  } ocm_e;
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pe_i,
  input  logic         upd_i,
  output logic [W-1:0] buf_o,
  output logic [W-1:0] act_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o <= RST_VAL;
      act_o <= RST_VAL;
    end else begin
      if (wr_i) buf_o <= wdata_i;
      // immediate write wins over a concurrent update
      if (wr_i && !pe_i) act_o <= wdata_i;
      else if (upd_i)    act_o <= buf_o;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cen_i,
  input  logic [CNT_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] div_q;
  logic tick;

  assign tick   = en_i && cen_i && !cnt_wr_i && (div_q == psc_i);
  assign wrap_o = tick && (cnt_o == arr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_o <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= wrap_o;
      if (en_i) begin
        if (cnt_wr_i) begin
          cnt_o <= cnt_wdata_i;
          div_q <= '0;
        end else if (cen_i) begin
          if (tick) begin
            div_q <= '0;
            cnt_o <= wrap_o ? '0 : cnt_o + 1'b1;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  ocm_e             mode_i,
  input  logic             oen_i,
  input  logic             en_i,
  output logic             pwm_o
);
  logic below, ref_lvl;

  assign below = cnt_i < cmp_i;

  always_comb begin
    case (mode_i)
      OCM_FORCE_HI: ref_lvl = 1'b1;
      OCM_PWM_LO:   ref_lvl = below;
      OCM_PWM_HI:   ref_lvl = !below;
      default:      ref_lvl = 1'b0;
    endcase
  end

  assign pwm_o = en_i && oen_i && ref_lvl;
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              pwm_o,
  output logic              update_o
);
  localparam logic [CNT_W-1:0] ARR_RST = {CNT_W{1'b1}};

  logic cen_q, arpe_q, cpe_q, oen_q;
  ocm_e ocm_q;
  logic wr_ok, cnt_wr, wrap;
  logic [CNT_W-1:0] psc_buf, psc_act, arr_buf, arr_act, cmp_buf, cmp_act, cnt_q;

  assign wr_ok  = wr_en_i && clk_en_i;
  assign cnt_wr = wr_ok && (addr_i == A_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q  <= 1'b0;
      arpe_q <= 1'b0;
      cpe_q  <= 1'b0;
      oen_q  <= 1'b0;
      ocm_q  <= ocm_e'(3'd0);
    end else if (wr_ok) begin
      case (addr_i)
        A_CTRL: begin
          cen_q  <= wdata_i[CTRL_RUN_BIT];
          arpe_q <= wdata_i[CTRL_ARP_BIT];
        end
        A_MODE: begin
          ocm_q <= ocm_e'(wdata_i[MODE_LSB +: 3]);
          cpe_q <= wdata_i[MODE_CPE_BIT];
        end
        A_OEN:   oen_q <= wdata_i[OEN_BIT];
        default: ;
      endcase
    end
  end

  pwm_shadow_reg #(.W(CNT_W), .RST_VAL('0)) u_psc (
    .clk_i, .rst_ni, .wr_i(wr_ok && addr_i == A_PSC), .wdata_i,
    .pe_i(1'b1), .upd_i(wrap), .buf_o(psc_buf), .act_o(psc_act)
  );

  pwm_shadow_reg #(.W(CNT_W), .RST_VAL(ARR_RST)) u_arr (
    .clk_i, .rst_ni, .wr_i(wr_ok && addr_i == A_ARR), .wdata_i,
    .pe_i(arpe_q), .upd_i(wrap), .buf_o(arr_buf), .act_o(arr_act)
  );

  pwm_shadow_reg #(.W(CNT_W), .RST_VAL('0)) u_cmp (
    .clk_i, .rst_ni, .wr_i(wr_ok && addr_i == A_CMP), .wdata_i,
    .pe_i(cpe_q), .upd_i(wrap), .buf_o(cmp_buf), .act_o(cmp_act)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i, .rst_ni, .en_i(clk_en_i), .cen_i(cen_q),
    .psc_i(psc_act), .arr_i(arr_act),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(wdata_i),
    .cnt_o(cnt_q), .wrap_o(wrap), .upd_o(update_o)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .cnt_i(cnt_q), .cmp_i(cmp_act), .mode_i(ocm_q),
    .oen_i(oen_q), .en_i(clk_en_i), .pwm_o
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[CTRL_RUN_BIT] = cen_q;
        rdata_o[CTRL_ARP_BIT] = arpe_q;
      end
      A_MODE: begin
        rdata_o[MODE_LSB +: 3]  = ocm_q;
        rdata_o[MODE_CPE_BIT]   = cpe_q;
      end
      A_OEN:   rdata_o[OEN_BIT] = oen_q;
      A_PSC:   rdata_o = psc_buf;
      A_ARR:   rdata_o = arr_buf;
      A_CNT:   rdata_o = cnt_q;
      A_CMP:   rdata_o = cmp_buf;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clk_en_i,
  input logic             pwm_o,
  input logic             update_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic             cen_i,
  input logic             oen_i,
  input logic [2:0]       mode_i,
  input logic             cnt_wr_i
);
  // R4: update pulse marks a counter sitting at zero
  a_r4_update_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> (cnt_i == '0));

  // R3: counter steps by one or wraps to zero, never jumps
  a_r3_step_or_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr_i |=> (cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) + 1'b1) || (cnt_i == '0));

  // R3: stopped counter holds
  a_r3_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_i && !cnt_wr_i) |=> $stable(cnt_i));

  // R9: gated block freezes and stays quiet
  a_r9_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> $stable(cnt_i));
  a_r9_pwm_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |-> !pwm_o);
  a_r9_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> !update_o);

  // R8: disabled channel is low
  a_r8_oen_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oen_i |-> !pwm_o);

  // R6: forced modes
  a_r6_force_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd5 && oen_i && clk_en_i) |-> pwm_o);
  a_r6_force_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd4) |-> !pwm_o);
endmodule

bind pwm_timer_top pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_i(clk_en_i), .pwm_o(pwm_o),
  .update_o(update_o), .cnt_i(cnt_q), .cen_i(cen_q), .oen_i(oen_q),
  .mode_i(ocm_q), .cnt_wr_i(cnt_wr)
);

// File: tb/tb_pwm_timer_top.sv
`timescale 1ns/1ps
module tb_pwm_timer_top;
  localparam int unsigned CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [CNT_W-1:0] wdata = '0;
  logic [CNT_W-1:0] rdata;
  logic pwm, upd;

  pwm_timer_top #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .update_o(upd)
  );

  always #4 clk = ~clk;

  typedef struct { int per; int hi; string req; } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0, n_win = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [CNT_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic push(int per, int hi, string req);
    exp_t e;
    e.per = per; e.hi = hi; e.req = req;
    q.push_back(e);
  endtask

  // monitor: one window per update pulse, pops an item when one is pending
  bit meas = 0;
  int per_c = 0, hi_c = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (upd) begin
      if (meas) begin
        chk({cur.req, " period"}, per_c, cur.per);
        chk({cur.req, " high"}, hi_c, cur.hi);
        n_win++;
      end
      meas = 0;
      if (q.size() > 0) begin
        cur = q.pop_front();
        meas = 1; per_c = 0; hi_c = 0;
      end
    end
    if (meas) begin
      per_c++;
      hi_c += int'(pwm);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int v, a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd4, v); chk("R1 arr reset", v, 16'hFFFF);
    rd(3'd0, v); chk("R1 ctrl reset", v, 0);
    rd(3'd6, v); chk("R1 cmp reset", v, 0);
    chk("R1 pwm low", int'(pwm), 0);
    chk("R1 update low", int'(upd), 0);

    clk_en = 1'b1;
    wr(3'd1, 16'h0060);           // mode 6, no preload
    wr(3'd4, 16'd9);              // immediate
    wr(3'd6, 16'd3);
    wr(3'd3, 16'd1);              // buffered
    rd(3'd3, v); chk("R2 psc readback", v, 1);
    rd(3'd4, v); chk("R2 arr readback", v, 9);
    wr(3'd2, 16'h0001);
    wr(3'd0, 16'h0081);           // run + arr preload
    wr(3'd1, 16'h0068);           // mode 6 + cmp preload
    rd(3'd1, v); chk("R2 mode readback", v, 16'h68);
    push(20, 6, "R4 R5 psc1 arr9 cmp3");
    wait (n_win == 1);

    wr(3'd6, 16'd0);
    push(20, 0, "R5 cmp zero");
    wait (n_win == 2);

    wr(3'd6, 16'd12);
    push(20, 20, "R5 cmp above arr");
    wait (n_win == 3);

    wr(3'd1, 16'h0078);
    wr(3'd6, 16'd3);
    push(20, 14, "R6 mode7");
    wait (n_win == 4);

    wr(3'd3, 16'd2);
    wr(3'd4, 16'd4);
    wr(3'd6, 16'd2);
    wr(3'd1, 16'h0068);
    push(15, 6, "R7 preload psc2 arr4 cmp2");
    wait (n_win == 5);

    wr(3'd1, 16'h0058);
    push(15, 15, "R6 force high");
    wait (n_win == 6);

    wr(3'd1, 16'h0048);
    push(15, 0, "R6 force low");
    wait (n_win == 7);

    wr(3'd1, 16'h0068);
    wr(3'd2, 16'h0000);
    push(15, 0, "R8 output disabled");
    wait (n_win == 8);
    wr(3'd2, 16'h0001);

    // R3 stopped counter holds
    wr(3'd0, 16'h0080);
    rd(3'd5, a);
    repeat (6) @(negedge clk);
    rd(3'd5, b);
    chk("R3 hold when stopped", b, a);

    // R10 counter write, R7 preload vs immediate compare
    wr(3'd5, 16'd1);
    rd(3'd5, v); chk("R10 cnt load", v, 1);
    chk("R5 cnt1 below cmp2", int'(pwm), 1);
    wr(3'd6, 16'd1);
    chk("R7 preloaded cmp not yet active", int'(pwm), 1);
    rd(3'd6, v); chk("R2 cmp readback", v, 1);
    wr(3'd1, 16'h0060);
    wr(3'd6, 16'd1);
    chk("R7 immediate cmp", int'(pwm), 0);

    // R9 gated block
    wr(3'd6, 16'd3);
    chk("R7 immediate cmp raise", int'(pwm), 1);
    @(negedge clk); clk_en = 1'b0;
    #1 chk("R9 pwm low when gated", int'(pwm), 0);
    wr(3'd4, 16'd7);
    rd(3'd4, v); chk("R9 write ignored", v, 4);
    @(negedge clk); clk_en = 1'b1;

    // R3 / R10 prescaler rate (psc active = 2)
    wr(3'd0, 16'h0001);
    wr(3'd5, 16'd0);
    repeat (2) @(negedge clk);
    rd(3'd5, v); chk("R3 before tick", v, 0);
    @(negedge clk);
    rd(3'd5, v); chk("R3 first tick", v, 1);
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R3 second tick", v, 2);

    // R6 undefined mode gives low
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'd0);
    wr(3'd1, 16'h0000);
    chk("R6 other mode low", int'(pwm), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule